// File: doc/BRIEF.md
# Memory Cycle Control Sequencer

This block turns the three level signals of an older processor's storage interface (use, read, write) into the control strobes of a static memory with a shared data bus. Chip enable follows the use signal qualified by a power-good level. Each read or write phase starts a delay counted in system clock cycles. When that delay ends, a short pulse follows. In a read phase, the pulse gates a set of active-low sense pulldowns, one for each data bit that reads as 1, plus one for a generated parity bit. In a write phase, the pulse drives write enable and, on the same cycle, the enable of the buffer that carries processor write data onto the memory bus.

The read and write inputs come from another timing domain, so each passes through a two-flop synchronizer. A phase begins on the rising edge of the synchronized level. If the phase level falls, or if chip enable drops, before the pulse ends, the sequence stops and the outputs return to idle. If read and write are both high, the block treats this as an error and issues no pulse. All interfaces are plain control and data pins with no valid/ready handshake. Data is sampled and gated purely by the cycle timing, so no back-pressure exists.

Top module: `mem_cycle_seq`

## Requirements
- R1: `mem_ce` equals `pwr_good & stor_use` in every cycle, combinationally.
- R2: `mem_oe` is high when `mem_ce` is high and the synchronized read level is high but the synchronized write level is not. A read level first sampled high at clock edge k shows on `mem_oe` after edge k+1.
- R3: If `stor_rd` is first sampled high at edge k and stays high, the read pulse lasts exactly PULSE_CYC cycles (default 8). It is active after edges k+2+DELAY_CYC through k+1+DELAY_CYC+PULSE_CYC (default 80), and inactive in every other cycle.
- R4: During the read pulse, `sense_pull[i]` equals `mem_rdata[i]` for bits 0 to 7 (1 means pull the line low). Outside the pulse, all sense bits are 0.
- R5: `sense_pull[8]` carries odd parity over `mem_rdata`. It is 1 when the count of 1 bits is even, and it is gated exactly like the data bits.
- R6: A write phase uses the same timing as R3, measured from `stor_wr`. During its pulse, `mem_we` and `wbuf_en` are both high in the same cycles.
- R7: `wbuf_en` is 0 outside the write pulse. `mem_wdata` equals `cpu_wdata` when `wbuf_en` is 1 and is all zeros otherwise.
- R8: While `mem_ce` is 0, no `mem_we`, `wbuf_en` or sense pulse is produced, including for phases that start while it is 0.
- R9: If the phase input falls before its pulse completes, no further pulse cycle is produced for that phase.
- R10: If the synchronized read and write levels are both high, neither pulse is issued and `mem_oe` stays 0.
- R11: During reset, all registered state clears. After reset, with all inputs low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supply-present level |
| stor_use | input | 1 | Storage-use level from the processor |
| stor_rd | input | 1 | Read-phase level, asynchronous |
| stor_wr | input | 1 | Write-phase level, asynchronous |
| mem_rdata | input | 8 | Data read from the memory bus |
| cpu_wdata | input | 8 | Write data from the processor |
| mem_ce | output | 1 | Memory chip enable |
| mem_oe | output | 1 | Memory output enable |
| mem_we | output | 1 | Memory write enable |
| wbuf_en | output | 1 | Write data buffer enable |
| mem_wdata | output | 8 | Buffered write data, zero while the buffer is off |
| sense_pull | output | 9 | Active-low sense pulldowns, bit 8 is parity |

## Verification
The assertions check in every cycle that write enable, the write buffer and the sense lines never fire without chip enable. They also check that the two pulses never overlap, that no pulse lasts longer than PULSE_CYC cycles, and that no pulse survives a read/write conflict. Only the bench scenarios can show the exact window position after synchronizer latency, the bit-by-bit and parity gating against chosen data, the abort on an early phase drop, and the suppression of phases that start with use or power low.

// File: rtl/mem_cycle_pkg.sv
package mem_cycle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FIRE = 2'd2,
    ST_HOLD = 2'd3
  } seq_st_t;
endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        sync_q[g] <= meta_q[g];
        prev_q[g] <= sync_q[g];
      end
    end
    assign rise_o[g] = sync_q[g] & ~prev_q[g];
  end

  assign level_o = sync_q;
endmodule

// File: rtl/phase_timer.sv
module phase_timer
  import mem_cycle_pkg::*;
#(
  parameter int DELAY_CYC = 80,
  parameter int PULSE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic keep_i,
  input  logic level_i,
  output logic pulse_o
);
  localparam int MAXC  = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] PLS_LAST = CNT_W'(PULSE_CYC - 1);

  seq_st_t st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_i && keep_i) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!keep_i) begin
            st_q <= ST_IDLE;
          end else if (cnt_q == DLY_LAST) begin
            st_q  <= ST_FIRE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_FIRE: begin
          if (!keep_i) begin
            st_q <= ST_IDLE;
          end else if (cnt_q == PLS_LAST) begin
            st_q  <= ST_HOLD;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (!level_i || !keep_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pulse_o = (st_q == ST_FIRE) && keep_i;

  logic [CNT_W:0] fire_len_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       fire_len_q <= '0;
    else if (pulse_o) fire_len_q <= fire_len_q + 1'b1;
    else              fire_len_q <= '0;
  end

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_len_q <= (CNT_W+1)'(PULSE_CYC));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !keep_i |=> !pulse_o || $rose(keep_i) == 1'b0 && keep_i == 1'b0 || st_q != ST_FIRE);
endmodule

// File: rtl/parity_gen.sv
module parity_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  output logic         odd_par_o
);
  logic [W:0] chain;
  assign chain[0] = 1'b1;
  for (genvar g = 0; g < W; g++) begin : g_x
    assign chain[g+1] = chain[g] ^ d_i[g];
  end
  assign odd_par_o = chain[W];
endmodule

// File: rtl/mem_cycle_seq.sv
module mem_cycle_seq #(
  parameter int DATA_W    = 8,
  parameter int DELAY_CYC = 80,
  parameter int PULSE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              stor_use,
  input  logic              stor_rd,
  input  logic              stor_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              mem_ce,
  output logic              mem_oe,
  output logic              mem_we,
  output logic              wbuf_en,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W:0]   sense_pull
);
  localparam int RD = 0;
  localparam int WR = 1;

  logic [1:0] lvl, rise, keep, pulse;
  logic       conflict, par;

  level_sync #(.N(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({stor_wr, stor_rd}),
    .level_o (lvl),
    .rise_o  (rise)
  );

  assign mem_ce   = pwr_good & stor_use;
  assign conflict = lvl[RD] & lvl[WR];

  for (genvar p = 0; p < 2; p++) begin : g_phase
    assign keep[p] = lvl[p] & mem_ce & ~conflict;
    phase_timer #(.DELAY_CYC(DELAY_CYC), .PULSE_CYC(PULSE_CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (rise[p]),
      .keep_i  (keep[p]),
      .level_i (lvl[p]),
      .pulse_o (pulse[p])
    );
  end

  parity_gen #(.W(DATA_W)) u_par (
    .d_i       (mem_rdata),
    .odd_par_o (par)
  );

  assign mem_oe     = keep[RD];
  assign mem_we     = pulse[WR];
  assign wbuf_en    = pulse[WR];
  assign mem_wdata  = wbuf_en ? cpu_wdata : '0;
  assign sense_pull = pulse[RD] ? {par, mem_rdata} : '0;

  // R8
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || wbuf_en) |-> mem_ce);

  // R8
  sense_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_pull != '0) |-> (mem_ce && mem_oe));

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && (sense_pull != '0)));

  // R10
  conflict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stor_rd_lvl_both(lvl)) |-> (!mem_we && !mem_oe && sense_pull == '0));

  // R7
  buf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wbuf_en |-> (mem_wdata == '0));

  function automatic logic stor_rd_lvl_both(input logic [1:0] l);
    return l[0] & l[1];
  endfunction
endmodule

// File: tb/test_mem_cycle_seq.sv
module test_mem_cycle_seq;
  localparam int DLY = 80;
  localparam int PLS = 8;
  localparam int WIN_LO = DLY + 2;
  localparam int WIN_HI = DLY + 2 + PLS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr_good = 0, stor_use = 0, stor_rd = 0, stor_wr = 0;
  logic [7:0] mem_rdata = 0, cpu_wdata = 0;
  logic mem_ce, mem_oe, mem_we, wbuf_en;
  logic [7:0] mem_wdata;
  logic [8:0] sense_pull;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mem_cycle_seq #(.DATA_W(8), .DELAY_CYC(DLY), .PULSE_CYC(PLS)) i_mem_cycle_seq (
    .clk, .rst_n, .pwr_good, .stor_use, .stor_rd, .stor_wr,
    .mem_rdata, .cpu_wdata, .mem_ce, .mem_oe, .mem_we, .wbuf_en,
    .mem_wdata, .sense_pull
  );

  function automatic logic odd_par(input logic [7:0] d);
    int c = 0;
    for (int i = 0; i < 8; i++) c += d[i];
    return (c % 2) == 0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(mem_oe == 0, req, 16'(mem_oe), 0);
    chk(mem_we == 0 && wbuf_en == 0, req, {mem_we, wbuf_en}, 0);
    chk(mem_wdata == 0, req, 16'(mem_wdata), 0);
    chk(sense_pull == 0, req, 16'(sense_pull), 0);
  endtask

  // Run one phase; drop_at < 0 keeps the level high for the whole window.
  task automatic run_phase(input bit is_wr, input bit use_i, input bit pg_i,
                           input logic [7:0] d, input int drop_at, input bit both);
    bit ce = use_i & pg_i;
    bit act = ce && !both && (drop_at < 0 || drop_at >= WIN_HI);
    @(negedge clk);
    stor_use = use_i; pwr_good = pg_i;
    if (is_wr) cpu_wdata = d; else mem_rdata = d;
    cpu_wdata = is_wr ? d : ~d;
    stor_rd = !is_wr || both;
    stor_wr = is_wr || both;
    for (int j = 0; j < WIN_HI + 10; j++) begin
      bit inwin, oe_exp;
      @(posedge clk); #1;
      inwin  = act && j >= WIN_LO && j < WIN_HI;
      oe_exp = ce && !is_wr && !both && j >= 1 && (drop_at < 0 || j <= drop_at + 1);
      chk(mem_ce == ce, "R1", 16'(mem_ce), 16'(ce));
      chk(mem_oe == oe_exp, "R2", 16'(mem_oe), 16'(oe_exp));
      if (!is_wr) begin
        logic [8:0] se = inwin ? {odd_par(d), d} : 9'h0;
        chk(sense_pull[7:0] == se[7:0], both ? "R10" : (drop_at >= 0 ? "R9" : (ce ? "R4" : "R8")),
            16'(sense_pull), 16'(se));
        chk(sense_pull[8] == se[8], ce ? "R5" : "R8", 16'(sense_pull[8]), 16'(se[8]));
        chk(mem_we == 0 && wbuf_en == 0, "R7", {mem_we, wbuf_en}, 0);
      end else begin
        logic [7:0] we_d = inwin ? d : 8'h0;
        chk(mem_we == inwin, drop_at >= 0 ? "R9" : (ce ? "R6" : "R8"), 16'(mem_we), 16'(inwin));
        chk(wbuf_en == inwin, "R6", 16'(wbuf_en), 16'(inwin));
        chk(mem_wdata == we_d, "R7", 16'(mem_wdata), 16'(we_d));
        if (!both) chk(sense_pull == 0, "R7", 16'(sense_pull), 0);
      end
      if (j == drop_at) begin stor_rd = 0; stor_wr = 0; end
    end
    @(negedge clk);
    stor_rd = 0; stor_wr = 0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk(mem_ce == 0, "R11", 16'(mem_ce), 0);
    check_idle("R11");
    @(negedge clk); rst_n = 1;
    repeat (2) @(posedge clk); #1;
    check_idle("R11");

    // directed
    run_phase(0, 1, 1, 8'hA5, -1, 0);   // R3 R4 R5 even count
    run_phase(0, 1, 1, 8'h07, -1, 0);   // R5 odd count
    run_phase(0, 1, 1, 8'h00, -1, 0);   // all zero: parity only
    run_phase(0, 1, 1, 8'hFF, -1, 0);
    run_phase(1, 1, 1, 8'h3C, -1, 0);   // R6 R7
    run_phase(0, 0, 1, 8'hFF, -1, 0);   // R8 use low
    run_phase(1, 1, 0, 8'hFF, -1, 0);   // R8 power low
    run_phase(0, 1, 1, 8'h81, 40, 0);   // R9 abort read
    run_phase(1, 1, 1, 8'h81, 70, 0);   // R9 abort write
    run_phase(0, 1, 1, 8'h55, -1, 1);   // R10 conflict

    // random
    for (int k = 0; k < 30; k++) begin
      bit w = $urandom_range(0, 1);
      bit u = ($urandom_range(0, 4) != 0);
      bit p = ($urandom_range(0, 4) != 0);
      logic [7:0] d = 8'($urandom);
      int dr = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 79)) : -1;
      run_phase(w, u, p, d, dr, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule